// File: doc/BRIEF.md
# Light-Load Burst Sequencer with Stepped Soft Ramps

This block decides, one switching cycle at a time, whether a resonant power stage keeps switching at light load, and which control-effort word goes to the frequency comparator. It compares a digitized feedback word against two programmable levels: a low level that sends the stage into burst operation and a high level that brings it out. It counts switching cycles into packets with a minimum length. It also scales the control effort in seven fixed steps, so that the transformer current rises at the start of a packet and falls at its end.

Two strobes stand in for the analog side. `cyc_stb` marks each switching cycle. `mid_stb` marks the moment the resonant-capacitor node crosses its midpoint, which ends the final pulse of a packet. Two mode inputs change the behaviour. `ramp_en` turns the soft ramps on or off. `burst_en` turns burst operation off altogether, in which case the effort word still has the low level as its floor.

In every requirement, base means the larger of `fb_val` and `thr_lo`. "Above" means strictly greater and "below" means strictly less. NBURST (default 16) is the minimum packet length in strobes. The step fraction for step k (1..7) is (5+2k)/21, applied as floor(base*(5+2k)/21). Step 0 means no scaling.

Top module: `bmode_sequencer`

## Requirements
- R1: After reset `sw_en` is 1, no ramp is active and `ctrl_eff` equals base.
- R2: During normal switching with `burst_en`=1, a `cyc_stb` with `fb_val` below `thr_lo` stops switching: `sw_en` is 0 from the next cycle. Without a strobe, nothing stops.
- R3: The first restart after entering burst operation waits for `fb_val` above `thr_hi`. A value between the levels keeps `sw_en` at 0. That first packet has no soft-on, so `ctrl_eff` equals base.
- R4: Every later restart happens on the cycle after `fb_val` rises above `thr_lo`. With `ramp_en`=1 it starts at step 1 and moves up one step per strobe: after step 7, the next strobe returns it to step 0. With `ramp_en`=0 there is no scaling.
- R5: While step k is active, `ctrl_eff` equals floor(base*(5+2k)/21) and follows `fb_val` in the same cycle.
- R6: Once a strobe has seen `fb_val` below `thr_lo` during a packet, switching goes on at least until the packet's strobe count reaches NBURST. The final pulse then lasts until `mid_stb`, after which `sw_en` is 0.
- R7: With ramps on, soft-off starts on the first strobe that has a pending stop and a count of at least NBURST-7. It shows steps 7 down to 1, one per strobe, and the strobe after step 1 begins the final pulse.
- R8: If `fb_val` rises above `thr_lo` during soft-off, the pending stop is dropped and soft-on resumes upward from the step in use.
- R9: If `fb_val` rises above `thr_hi` during soft-on, the ramp ends at once and `ctrl_eff` equals base unscaled.
- R10: `zcd_en` is 1 exactly when `fb_val` is above `thr_hi`.
- R11: During a packet, NBURST+1 consecutive strobes with `fb_val` above `thr_hi` return the block to normal switching. NBURST such strobes do not.
- R12: With `burst_en`=0, `sw_en` is 1 from the next cycle on and never falls, and `ctrl_eff` equals base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_val | input | DW | Digitized feedback |
| thr_lo | input | DW | Burst entry level |
| thr_hi | input | DW | Burst exit level |
| cyc_stb | input | 1 | One pulse per switching cycle |
| mid_stb | input | 1 | Midpoint crossing, ends the final pulse |
| ramp_en | input | 1 | Soft ramps enabled |
| burst_en | input | 1 | Burst operation enabled |
| sw_en | output | 1 | Switching enable |
| ctrl_eff | output | DW | Scaled control effort |
| zcd_en | output | 1 | Zero-current detection enable |

## Verification
`ctrl_eff` and `zcd_en` are combinational in `fb_val` and the registered step, so they are due in the same cycle as a feedback change. Changes of state, step and `sw_en` are due one clock after the strobe or threshold crossing that causes them. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. Feedback-only sweeps are sampled a moment after the change, with no strobe pending.

// File: rtl/bmode_pkg.sv
package bmode_pkg;
  typedef enum logic [1:0] {BM_RUN, BM_OFF, BM_ON, BM_LAST} bm_state_e;
  typedef enum logic [1:0] {RMP_NONE, RMP_UP, RMP_DOWN} bm_dir_e;

  localparam int unsigned BM_STEPS = 7;
  localparam int unsigned BM_DEN   = 21;

  // numerator over 21 for step k: 7, 9, ..., 19
  function automatic logic [4:0] bm_numer(input logic [2:0] k);
    return 5'(5 + 2 * int'(k));
  endfunction
endpackage

// File: rtl/bmode_level.sv
module bmode_level #(
  parameter int unsigned DW = 10
) (
  input  logic [DW-1:0] fb,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          below_lo,
  output logic          above_lo,
  output logic          above_hi,
  output logic [DW-1:0] base
);
  always_comb begin
    below_lo = (fb < lo);
    above_lo = (fb > lo);
    above_hi = (fb > hi);
    base     = above_lo ? fb : lo;
  end
endmodule

// File: rtl/bmode_scale.sv
module bmode_scale
  import bmode_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic [DW-1:0] base,
  input  logic [2:0]    step,
  output logic [DW-1:0] eff
);
  localparam int unsigned PW = DW + 5;

  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(base) * PW'(bm_numer(step));
    if (step == 3'd0) eff = base;
    else              eff = DW'(prod / PW'(BM_DEN));
  end
endmodule

// File: rtl/bmode_fsm.sv
module bmode_fsm
  import bmode_pkg::*;
#(
  parameter int unsigned NBURST = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_stb,
  input  logic      mid_stb,
  input  logic      ramp_en,
  input  logic      burst_en,
  input  logic      below_lo,
  input  logic      above_lo,
  input  logic      above_hi,
  output bm_state_e st,
  output logic [2:0] step,
  output logic      sw_en
);
  localparam int unsigned CW = $clog2(NBURST + 2);
  localparam logic [CW-1:0] NB_C    = CW'(NBURST);
  localparam logic [CW-1:0] SOFT_C  = CW'(NBURST - BM_STEPS);
  localparam logic [CW-1:0] HIC_MAX = CW'(NBURST + 1);
  localparam logic [2:0]    TOP_ST  = 3'(BM_STEPS);

  bm_state_e     st_q, st_d;
  bm_dir_e       dir_q, dir_d;
  logic [2:0]    step_q, step_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] hic_q, hic_d, hic_inc;
  logic          drain_q, drain_d, drain_nx;
  logic          first_q, first_d;

  always_comb begin
    st_d    = st_q;
    dir_d   = dir_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    hic_d   = hic_q;
    drain_d = drain_q;
    first_d = first_q;

    cnt_inc  = (cnt_q == NB_C) ? cnt_q : cnt_q + 1'b1;
    hic_inc  = !above_hi ? '0 : ((hic_q == HIC_MAX) ? hic_q : hic_q + 1'b1);
    drain_nx = drain_q | below_lo;

    if (!burst_en) begin
      st_d = BM_RUN; dir_d = RMP_NONE; step_d = '0;
      cnt_d = '0; hic_d = '0; drain_d = 1'b0; first_d = 1'b0;
    end else begin
      unique case (st_q)
        BM_RUN: begin
          if (cyc_stb && below_lo) begin
            st_d = BM_OFF; first_d = 1'b1;
            dir_d = RMP_NONE; step_d = '0; cnt_d = '0; hic_d = '0; drain_d = 1'b0;
          end
        end
        BM_OFF: begin
          if (first_q ? above_hi : above_lo) begin
            st_d = BM_ON; first_d = 1'b0;
            cnt_d = '0; hic_d = '0; drain_d = 1'b0;
            if (!first_q && ramp_en) begin
              dir_d = RMP_UP; step_d = 3'd1;
            end
          end
        end
        BM_ON: begin
          if (cyc_stb) begin
            cnt_d = cnt_inc;
            hic_d = hic_inc;
          end
          if (cyc_stb && (hic_inc == HIC_MAX)) begin
            st_d = BM_RUN; dir_d = RMP_NONE; step_d = '0;
            cnt_d = '0; hic_d = '0; drain_d = 1'b0;
          end else if (dir_q == RMP_UP && above_hi) begin
            dir_d = RMP_NONE; step_d = '0;
          end else if (dir_q == RMP_DOWN && above_lo) begin
            dir_d = RMP_UP; drain_d = 1'b0;
          end else if (cyc_stb) begin
            drain_d = drain_nx;
            if (drain_nx && ramp_en && (cnt_inc >= SOFT_C) && (dir_q != RMP_DOWN)) begin
              dir_d  = RMP_DOWN;
              step_d = (step_q == 3'd0) ? TOP_ST : step_q;
            end else if (dir_q == RMP_DOWN) begin
              if (step_q == 3'd1) st_d = BM_LAST;
              else                step_d = step_q - 3'd1;
            end else if (dir_q == RMP_UP) begin
              if (step_q == TOP_ST) begin
                step_d = '0; dir_d = RMP_NONE;
              end else begin
                step_d = step_q + 3'd1;
              end
            end else if (drain_nx && (cnt_inc >= NB_C)) begin
              st_d = BM_LAST;
            end
          end
        end
        BM_LAST: begin
          if (mid_stb) begin
            st_d = BM_OFF; dir_d = RMP_NONE; step_d = '0;
            cnt_d = '0; hic_d = '0; drain_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BM_RUN;
      dir_q   <= RMP_NONE;
      step_q  <= '0;
      cnt_q   <= '0;
      hic_q   <= '0;
      drain_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      dir_q   <= dir_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      hic_q   <= hic_d;
      drain_q <= drain_d;
      first_q <= first_d;
    end
  end

  assign st    = st_q;
  assign step  = step_q;
  assign sw_en = (st_q != BM_OFF);
endmodule

// File: rtl/bmode_sequencer.sv
module bmode_sequencer
  import bmode_pkg::*;
#(
  parameter int unsigned DW     = 10,
  parameter int unsigned NBURST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] fb_val,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic          cyc_stb,
  input  logic          mid_stb,
  input  logic          ramp_en,
  input  logic          burst_en,
  output logic          sw_en,
  output logic [DW-1:0] ctrl_eff,
  output logic          zcd_en
);
  logic          rst_meta_n, rst_sync_n;
  logic          below_lo, above_lo, above_hi;
  logic [DW-1:0] base;
  logic [2:0]    step;
  bm_state_e     cur_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bmode_level #(.DW(DW)) u_level (
    .fb       (fb_val),
    .lo       (thr_lo),
    .hi       (thr_hi),
    .below_lo (below_lo),
    .above_lo (above_lo),
    .above_hi (above_hi),
    .base     (base)
  );

  bmode_fsm #(.NBURST(NBURST)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cyc_stb  (cyc_stb),
    .mid_stb  (mid_stb),
    .ramp_en  (ramp_en),
    .burst_en (burst_en),
    .below_lo (below_lo),
    .above_lo (above_lo),
    .above_hi (above_hi),
    .st       (cur_st),
    .step     (step),
    .sw_en    (sw_en)
  );

  bmode_scale #(.DW(DW)) u_scale (
    .base (base),
    .step (step),
    .eff  (ctrl_eff)
  );

  assign zcd_en = above_hi;
endmodule

// File: rtl/bmode_sequencer_chk.sv
module bmode_sequencer_chk
  import bmode_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_stb,
  input logic          mid_stb,
  input logic          burst_en,
  input logic [DW-1:0] fb_val,
  input logic [DW-1:0] thr_lo,
  input logic [DW-1:0] ctrl_eff,
  input logic          sw_en,
  input bm_state_e     st
);
  logic [DW-1:0] ref_base;
  assign ref_base = (fb_val > thr_lo) ? fb_val : thr_lo;

  AST_ENTRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BM_RUN && burst_en && cyc_stb && fb_val < thr_lo) |=> !sw_en); // R2

  AST_NOBURST_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> sw_en); // R12

  AST_EFF_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_eff <= ref_base); // R5

  AST_EFF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_eff >= ref_base / 3); // R5

  AST_STOP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> ($past(cyc_stb) || $past(mid_stb))); // R6
endmodule

bind bmode_sequencer bmode_sequencer_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cyc_stb  (cyc_stb),
  .mid_stb  (mid_stb),
  .burst_en (burst_en),
  .fb_val   (fb_val),
  .thr_lo   (thr_lo),
  .ctrl_eff (ctrl_eff),
  .sw_en    (sw_en),
  .st       (cur_st)
);

// File: tb/bmode_sequencer_test.sv
`timescale 1ns/1ps
module bmode_sequencer_test;
  localparam int DW = 10;
  localparam int NB = 16;
  localparam int LO = 200;
  localparam int HI = 400;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] fb_val, thr_lo, thr_hi;
  logic          cyc_stb, mid_stb, ramp_en, burst_en;
  logic          sw_en, zcd_en;
  logic [DW-1:0] ctrl_eff;

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;

  always #10 clk = ~clk;

  bmode_sequencer #(.DW(DW), .NBURST(NB)) uut (
    .clk(clk), .rst_n(rst_n), .fb_val(fb_val), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .cyc_stb(cyc_stb), .mid_stb(mid_stb), .ramp_en(ramp_en), .burst_en(burst_en),
    .sw_en(sw_en), .ctrl_eff(ctrl_eff), .zcd_en(zcd_en)
  );

  function automatic int frac(input int b, input int k);
    return (k == 0) ? b : (b * (5 + 2 * k)) / 21;
  endfunction

  function automatic int basev(input int f);
    return (f > LO) ? f : LO;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive for one rising edge, sample after the following falling edge
  task automatic tick(input logic s, input logic m);
    cyc_stb = s; mid_stb = m;
    @(negedge clk);
    cyc_stb = 1'b0; mid_stb = 1'b0;
    #1;
  endtask

  task automatic setfb(input int v);
    fb_val = DW'(v);
    #1;
  endtask

  task automatic sweep_step(input int k);
    for (int v = LO + 1; v <= HI; v++) begin
      setfb(v);
      chk("R5 step scaling", int'(ctrl_eff), frac(v, k));
    end
    setfb(300);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_stb = 1'b0; mid_stb = 1'b0;
    ramp_en = 1'b1; burst_en = 1'b1;
    thr_lo = DW'(LO); thr_hi = DW'(HI); fb_val = DW'(300);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    chk("R1 sw_en", int'(sw_en), 1);
    chk("R1 effort", int'(ctrl_eff), 300);
    setfb(100);
    chk("R1 effort floor", int'(ctrl_eff), LO);
    // R10 zcd flag across the exit level
    setfb(HI);   chk("R10 zcd at level", int'(zcd_en), 0);
    setfb(HI+1); chk("R10 zcd above", int'(zcd_en), 1);
    chk("R1 effort high", int'(ctrl_eff), HI+1);

    // R2 entry only on strobe
    setfb(100);
    tick(0, 0); chk("R2 no strobe keeps switching", int'(sw_en), 1);
    tick(1, 0); chk("R2 strobe stops", int'(sw_en), 0);

    // R3 first restart needs high level
    setfb(300);
    tick(0, 0); tick(0, 0);
    chk("R3 between levels stays off", int'(sw_en), 0);
    setfb(450);
    tick(0, 0);
    chk("R3 restart", int'(sw_en), 1);
    chk("R3 no soft-on", int'(ctrl_eff), 450);

    // first packet: 3 strobes, stop request on 4th
    setfb(300);
    for (int i = 0; i < 3; i++) begin
      tick(1, 0); chk("R3 unscaled", int'(ctrl_eff), 300);
    end
    setfb(100);
    for (int i = 4; i <= 8; i++) begin
      tick(1, 0);
      chk("R6 still switching", int'(sw_en), 1);
      chk("R6 unscaled before soft-off", int'(ctrl_eff), LO);
    end
    // R7 soft-off from count NB-7
    for (int k = 7; k >= 1; k--) begin
      tick(1, 0);
      chk("R7 soft-off step", int'(ctrl_eff), frac(LO, k));
      chk("R7 switching", int'(sw_en), 1);
    end
    tick(1, 0);
    chk("R6 final pulse", int'(sw_en), 1);
    tick(0, 0);
    chk("R6 waits for midpoint", int'(sw_en), 1);
    tick(0, 1);
    chk("R6 off after midpoint", int'(sw_en), 0);

    // R4 later restart above low level with soft-on
    setfb(300);
    tick(0, 0);
    chk("R4 restart", int'(sw_en), 1);
    chk("R4 step1", int'(ctrl_eff), frac(300, 1));
    sweep_step(1);
    for (int k = 2; k <= 7; k++) begin
      tick(1, 0);
      chk("R4 soft-on step", int'(ctrl_eff), frac(300, k));
      sweep_step(k);
    end
    tick(1, 0);
    chk("R4 ramp done", int'(ctrl_eff), 300);

    // R8 reversal: stop request at count 8, soft-off 7,6,5 then rise
    setfb(100);
    tick(1, 0);
    for (int k = 7; k >= 5; k--) begin
      tick(1, 0); chk("R8 soft-off", int'(ctrl_eff), frac(LO, k));
    end
    setfb(300);
    tick(0, 0);
    chk("R8 keeps step", int'(ctrl_eff), frac(300, 5));
    tick(1, 0); chk("R8 up", int'(ctrl_eff), frac(300, 6));
    tick(1, 0); chk("R8 up", int'(ctrl_eff), frac(300, 7));
    // R9 abort on high level
    setfb(450);
    tick(0, 0);
    chk("R9 abort unscaled", int'(ctrl_eff), 450);

    // R11 NB strobes above high do not exit
    for (int i = 0; i < NB; i++) tick(1, 0);
    setfb(100);
    tick(1, 0);
    chk("R11 still in packet", int'(sw_en), 1);
    chk("R7 late soft-off start", int'(ctrl_eff), frac(LO, 7));
    for (int k = 6; k >= 1; k--) begin
      tick(1, 0); chk("R7 late soft-off", int'(ctrl_eff), frac(LO, k));
    end
    tick(1, 0);
    tick(0, 1);
    chk("R6 off", int'(sw_en), 0);

    // R11 NB+1 strobes above high exit
    setfb(300);
    tick(0, 0);
    setfb(450);
    tick(0, 0);
    chk("R9 abort", int'(ctrl_eff), 450);
    for (int i = 0; i < NB + 1; i++) tick(1, 0);
    chk("R11 switching", int'(sw_en), 1);
    setfb(100);
    tick(1, 0);
    chk("R11 back to normal, entry stops", int'(sw_en), 0);

    // ramps disabled
    ramp_en = 1'b0;
    setfb(450);
    tick(0, 0);
    chk("R3 restart no ramp", int'(sw_en), 1);
    setfb(100);
    for (int i = 1; i <= NB - 1; i++) begin
      tick(1, 0);
      chk("R6 packet minimum", int'(sw_en), 1);
      chk("R4 no scaling", int'(ctrl_eff), LO);
    end
    tick(1, 0);
    tick(0, 1);
    chk("R6 stop at count", int'(sw_en), 0);
    setfb(300);
    tick(0, 0);
    chk("R4 restart above low", int'(sw_en), 1);
    chk("R4 no soft-on", int'(ctrl_eff), 300);

    // R12 burst disabled
    burst_en = 1'b0;
    tick(0, 0);
    setfb(100);
    for (int i = 0; i < 4; i++) begin
      tick(1, 0);
      chk("R12 never stops", int'(sw_en), 1);
      chk("R12 floor", int'(ctrl_eff), LO);
    end
    burst_en = 1'b1;
    tick(1, 0);
    chk("R2 entry again", int'(sw_en), 0);
    burst_en = 1'b0;
    tick(0, 0);
    chk("R12 leaves burst", int'(sw_en), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule